// File: doc/BRIEF.md
# Stereo PWM Audio Output Stage

This block turns a stream of signed 16-bit stereo samples into four pulse-width-modulated pad signals. Each channel has a P leg and an N leg and drives a filterless speaker bridge. A free-running counter sets the length of the PWM frame. The block pulls one sample pair over a ready/valid handshake at the end of every frame. If no pair is offered at that point, the held pair is played again.

Control inputs select the following:
- run: gates all modulation.
- Per-channel enables.
- Mono: both channels play the left sample.
- Remap mode: only one leg modulates, picked by the sample's sign; the other leg stays low.
- Output inversion.
- False-run: samples keep being consumed, but the pads stay at a fixed level.
- Idle pad pattern: the level used whenever the pads are not modulating.

A rising edge on the soft-reset input makes a one-cycle internal clear. That clear zeroes the frame counter and the held samples.

Top module: `pwm_audio_out`

## Requirements
- R1: While rst_ni is low, all four pad data outputs are 0, all four output enables are 0, and smp_ready_o is 0.
- R2: While run_i is high, the frame is 2^FRAME_BITS cycles and smp_ready_o is high for exactly one cycle per frame. A sample pair is taken only when smp_ready_o and smp_valid_i are both high. Otherwise the held pair is repeated in every following frame.
- R3: With remap off and the channel active, the P leg is high for ceil((s+2^(SAMPLE_W-1)) / 2^(SAMPLE_W-FRAME_BITS)) cycles of each frame, where s is the signed sample. The N leg is its complement, so s=0 gives 50% duty.
- R4: With remap on, a positive sample drives P high for ceil(s/2^(SAMPLE_W-FRAME_BITS)) cycles per frame while N stays low. A negative sample drives N high for ceil(-s/2^(SAMPLE_W-FRAME_BITS)) cycles while P stays low. A zero sample gives no pulse on either leg.
- R5: With mono_i high, the right pads are modulated from the left sample.
- R6: A channel whose enable is low drives the idle pattern on its pads and does not modulate. The other channel is not affected.
- R7: When run_i is low, the pads show the idle pattern selected by idle_lvl_i:
  - 0: all data low.
  - 1: all data high.
  - 2: P legs high, N legs low.
  - 3: all output enables low.
  In codes 0 to 2 every enable is high. pad_oe_o bit order is {RN, RP, LN, LP}.
- R8: With false_run_i high and run_i high, the pads hold the idle pattern. smp_ready_o still pulses once per frame and samples are still consumed.
- R9: invert_i inverts the four pad data outputs as the final stage. It never changes pad_oe_o.
- R10: A rising edge on soft_rst_i makes a clear pulse exactly one cycle long, however long the input stays high. The clear zeroes the frame counter and both held samples.
- R11: Pad outputs are registered. They follow the control and modulator state of the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Enable frame counting and modulation |
| soft_rst_i | input | 1 | Soft reset command, rising edge acts |
| mono_i | input | 1 | Right channel plays left sample |
| left_en_i | input | 1 | Left channel enable |
| right_en_i | input | 1 | Right channel enable |
| remap_i | input | 1 | Single-leg sign-dependent modulation |
| invert_i | input | 1 | Invert pad data outputs |
| false_run_i | input | 1 | Consume samples, hold pads at idle |
| idle_lvl_i | input | 2 | Idle pad pattern code |
| smp_valid_i | input | 1 | Sample pair offered |
| smp_ready_o | output | 1 | Sample pair taken this cycle |
| smp_left_i | input | SAMPLE_W | Left signed sample |
| smp_right_i | input | SAMPLE_W | Right signed sample |
| pad_lp_o | output | 1 | Left P pad data |
| pad_ln_o | output | 1 | Left N pad data |
| pad_rp_o | output | 1 | Right P pad data |
| pad_rn_o | output | 1 | Right N pad data |
| pad_oe_o | output | 4 | Pad output enables {RN, RP, LN, LP} |

## Verification
The assertions assume FRAME_BITS is at least 2 and SAMPLE_W is larger than FRAME_BITS. They also assume mode inputs are sampled at the clock edge, so each output check uses the inputs of the cycle before. The stimulus changes mode and sample inputs only at falling edges. Before it counts duty over a window, it lets two whole frames load the same pair, so the one-cycle pad latency cannot mix two samples into one count. The soft reset is held high for several cycles to show that only its rising edge acts.

// File: rtl/pwm_audio_pkg.sv
package pwm_audio_pkg;
  typedef enum logic [1:0] {
    IDLE_LOW   = 2'd0,
    IDLE_HIGH  = 2'd1,
    IDLE_SPLIT = 2'd2,
    IDLE_FLOAT = 2'd3
  } idle_e;
endpackage

// File: rtl/pwm_frame_ctr.sv
module pwm_frame_ctr #(
  parameter int FRAME_BITS = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic                  clr_i,
  output logic [FRAME_BITS-1:0] cnt_o,
  output logic                  last_o
);
  logic [FRAME_BITS-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || !run_i) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = run_i && (cnt_q == '1);

  a_r2_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i) |=> cnt_q == FRAME_BITS'($past(cnt_q) + 1'b1));
  a_r2_last_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o);
  a_r10_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/pwm_chan_mod.sv
module pwm_chan_mod #(
  parameter int SAMPLE_W   = 16,
  parameter int FRAME_BITS = 6
) (
  input  logic [FRAME_BITS-1:0] cnt_i,
  input  logic [SAMPLE_W-1:0]   smp_i,
  input  logic                  remap_i,
  output logic                  p_o,
  output logic                  n_o
);
  localparam int LOW_W = SAMPLE_W - FRAME_BITS;

  logic [SAMPLE_W-1:0] pos, offs, mag;
  logic                neg;

  // counter scaled to sample range; residual low bits round duty up
  assign pos  = {cnt_i, {LOW_W{1'b0}}};
  assign neg  = smp_i[SAMPLE_W-1];
  assign offs = {~neg, smp_i[SAMPLE_W-2:0]};
  assign mag  = neg ? (~smp_i + 1'b1) : smp_i;

  always_comb begin
    if (remap_i) begin
      p_o = !neg && (pos < mag);
      n_o =  neg && (pos < mag);
    end else begin
      p_o = pos < offs;
      n_o = !p_o;
    end
  end
endmodule

// File: rtl/pwm_pad_stage.sv
module pwm_pad_stage
  import pwm_audio_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           active_i,
  input  logic           remap_i,
  input  logic           invert_i,
  input  idle_e          idle_i,
  input  logic [NCH-1:0] ch_en_i,
  input  logic [NCH-1:0] mod_p_i,
  input  logic [NCH-1:0] mod_n_i,
  output logic [NCH-1:0] pad_p_o,
  output logic [NCH-1:0] pad_n_o,
  output logic [NCH-1:0] oe_o
);
  logic idle_p, idle_n, idle_oe;

  always_comb begin
    unique case (idle_i)
      IDLE_LOW:   {idle_p, idle_n, idle_oe} = 3'b001;
      IDLE_HIGH:  {idle_p, idle_n, idle_oe} = 3'b111;
      IDLE_SPLIT: {idle_p, idle_n, idle_oe} = 3'b101;
      default:    {idle_p, idle_n, idle_oe} = 3'b000;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic nxt_p, nxt_n, nxt_oe, live;
    assign live = active_i && ch_en_i[c];

    always_comb begin
      if (live) begin
        nxt_p  = mod_p_i[c];
        nxt_n  = mod_n_i[c];
        nxt_oe = 1'b1;
      end else begin
        nxt_p  = idle_p;
        nxt_n  = idle_n;
        nxt_oe = idle_oe;
      end
    end

    // inversion touches data only, never the enables
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pad_p_o[c] <= 1'b0;
        pad_n_o[c] <= 1'b0;
        oe_o[c]    <= 1'b0;
      end else begin
        pad_p_o[c] <= nxt_p ^ invert_i;
        pad_n_o[c] <= nxt_n ^ invert_i;
        oe_o[c]    <= nxt_oe;
      end
    end

    a_r3_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && !remap_i) |=> pad_p_o[c] != pad_n_o[c]);
    a_r4_one_leg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && remap_i && !invert_i) |=> !(pad_p_o[c] && pad_n_o[c]));
    a_r7_float_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!live && idle_i == IDLE_FLOAT) |=> !oe_o[c]);
    a_r9_oe_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live |=> oe_o[c]);
  end
endmodule

// File: rtl/pwm_audio_out.sv
module pwm_audio_out
  import pwm_audio_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int FRAME_BITS = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                soft_rst_i,
  input  logic                mono_i,
  input  logic                left_en_i,
  input  logic                right_en_i,
  input  logic                remap_i,
  input  logic                invert_i,
  input  logic                false_run_i,
  input  logic [1:0]          idle_lvl_i,
  input  logic                smp_valid_i,
  output logic                smp_ready_o,
  input  logic [SAMPLE_W-1:0] smp_left_i,
  input  logic [SAMPLE_W-1:0] smp_right_i,
  output logic                pad_lp_o,
  output logic                pad_ln_o,
  output logic                pad_rp_o,
  output logic                pad_rn_o,
  output logic [3:0]          pad_oe_o
);
  localparam int NCH = 2;

  logic                  srst_d, srst_q;
  logic [FRAME_BITS-1:0] cnt;
  logic                  last;
  logic [SAMPLE_W-1:0]   left_q, right_q;
  logic [SAMPLE_W-1:0]   ch_smp [NCH];
  logic [NCH-1:0]        mod_p, mod_n, pad_p, pad_n, oe;

  // rising edge of command -> single clear cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_d <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      srst_d <= soft_rst_i;
      srst_q <= soft_rst_i && !srst_d;
    end
  end

  pwm_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .clr_i  (srst_q),
    .cnt_o  (cnt),
    .last_o (last)
  );

  assign smp_ready_o = last && !srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (srst_q) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (smp_ready_o && smp_valid_i) begin
      left_q  <= smp_left_i;
      right_q <= smp_right_i;
    end
  end

  assign ch_smp[0] = left_q;
  assign ch_smp[1] = mono_i ? left_q : right_q;

  for (genvar c = 0; c < NCH; c++) begin : g_mod
    pwm_chan_mod #(.SAMPLE_W(SAMPLE_W), .FRAME_BITS(FRAME_BITS)) u_mod (
      .cnt_i   (cnt),
      .smp_i   (ch_smp[c]),
      .remap_i (remap_i),
      .p_o     (mod_p[c]),
      .n_o     (mod_n[c])
    );
  end

  pwm_pad_stage #(.NCH(NCH)) u_pads (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (run_i && !false_run_i),
    .remap_i  (remap_i),
    .invert_i (invert_i),
    .idle_i   (idle_e'(idle_lvl_i)),
    .ch_en_i  ({right_en_i, left_en_i}),
    .mod_p_i  (mod_p),
    .mod_n_i  (mod_n),
    .pad_p_o  (pad_p),
    .pad_n_o  (pad_n),
    .oe_o     (oe)
  );

  assign pad_lp_o = pad_p[0];
  assign pad_ln_o = pad_n[0];
  assign pad_rp_o = pad_p[1];
  assign pad_rn_o = pad_n[1];
  assign pad_oe_o = {oe[1], oe[1], oe[0], oe[0]};

  a_r10_srst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> !srst_q);
  a_r10_srst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (left_q == '0 && right_q == '0));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_q && !(smp_ready_o && smp_valid_i)) |=> $stable(left_q) && $stable(right_q));
  a_r5_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mono_i && left_en_i && right_en_i && run_i && !false_run_i)
      |=> (pad_lp_o == pad_rp_o && pad_ln_o == pad_rn_o));
endmodule

// File: tb/pwm_audio_out_test.sv
module pwm_audio_out_test;
  localparam int SW    = 16;
  localparam int FB    = 6;
  localparam int FRAME = 1 << FB;
  localparam int SCALE = 1 << (SW - FB);
  localparam int HALF  = 1 << (SW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, srst = 0, mono = 0, len = 0, ren = 0, remap = 0, inv = 0, frun = 0;
  logic [1:0] idle = 2'd0;
  logic valid = 0;
  logic ready;
  logic [SW-1:0] sl = '0, sr = '0;
  logic lp, ln, rp, rn;
  logic [3:0] oe;

  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_audio_out #(.SAMPLE_W(SW), .FRAME_BITS(FB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .soft_rst_i(srst), .mono_i(mono),
    .left_en_i(len), .right_en_i(ren), .remap_i(remap), .invert_i(inv),
    .false_run_i(frun), .idle_lvl_i(idle), .smp_valid_i(valid), .smp_ready_o(ready),
    .smp_left_i(sl), .smp_right_i(sr), .pad_lp_o(lp), .pad_ln_o(ln),
    .pad_rp_o(rp), .pad_rn_o(rn), .pad_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_p(input int s, input bit rm);
    if (!rm) return (s + HALF + SCALE - 1) / SCALE;
    return (s > 0) ? (s + SCALE - 1) / SCALE : 0;
  endfunction

  function automatic int exp_n(input int s, input bit rm);
    if (!rm) return FRAME - exp_p(s, 1'b0);
    return (s < 0) ? (-s + SCALE - 1) / SCALE : 0;
  endfunction

  int c_lp, c_ln, c_rp, c_rn;

  task automatic measure();
    c_lp = 0; c_ln = 0; c_rp = 0; c_rn = 0;
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      c_lp += int'(lp); c_ln += int'(ln); c_rp += int'(rp); c_rn += int'(rn);
    end
  endtask

  task automatic play(input int l, input int r);
    int hs = 0;
    sl = SW'(l); sr = SW'(r); valid = 1'b1;
    while (hs < 2) begin
      @(negedge clk);
      if (ready && valid) hs++;
    end
    measure();
  endtask

  task automatic check_static(input string req, input logic [3:0] dat, input logic [3:0] en);
    repeat (3) @(negedge clk);
    chk({rn, rp, ln, lp} == dat, req, "pad data", int'({rn, rp, ln, lp}), int'(dat));
    chk(oe == en, req, "pad oe", int'(oe), int'(en));
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({rn, rp, ln, lp} == 4'b0, "R1", "pads in reset", int'({rn, rp, ln, lp}), 0);
    chk(oe == 4'b0, "R1", "oe in reset", int'(oe), 0);
    chk(!ready, "R1", "ready in reset", int'(ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1; len = 1; ren = 1;

    // R2 one ready per frame, never back to back
    begin
      int n = 0; bit prev = 0; bit dbl = 0;
      for (int i = 0; i < 4 * FRAME; i++) begin
        @(negedge clk);
        if (ready) n++;
        if (ready && prev) dbl = 1;
        prev = ready;
      end
      chk(n == 4, "R2", "ready pulses in 4 frames", n, 4);
      chk(!dbl, "R2", "ready back-to-back", int'(dbl), 0);
    end

    // R3 / R4 sweeps, remap off then on
    for (int m = 0; m < 2; m++) begin
      remap = m[0];
      for (int i = 0; i <= FRAME; i++) begin
        int s = (i == FRAME) ? HALF - 1 : -HALF + i * 1040;
        int t = -s - 1;
        string rq = m ? "R4" : "R3";
        play(s, t);
        chk(c_lp == exp_p(s, remap), rq, "left P duty", c_lp, exp_p(s, remap));
        chk(c_ln == exp_n(s, remap), rq, "left N duty", c_ln, exp_n(s, remap));
        chk(c_rp == exp_p(t, remap), rq, "right P duty", c_rp, exp_p(t, remap));
        chk(c_rn == exp_n(t, remap), rq, "right N duty", c_rn, exp_n(t, remap));
      end
    end
    remap = 1;
    play(0, 0);
    chk(c_lp + c_ln == 0, "R4", "zero sample no pulse", c_lp + c_ln, 0);
    remap = 0;

    // R2 repeat when no sample offered
    play(12345, -2000);
    valid = 0;
    repeat (2 * FRAME) @(negedge clk);
    sl = SW'(-30000); sr = SW'(30000);
    measure();
    chk(c_lp == exp_p(12345, 0), "R2", "repeat left", c_lp, exp_p(12345, 0));
    chk(c_rp == exp_p(-2000, 0), "R2", "repeat right", c_rp, exp_p(-2000, 0));

    // R5 mono
    mono = 1;
    play(20000, -20000);
    chk(c_rp == exp_p(20000, 0), "R5", "mono right P", c_rp, exp_p(20000, 0));
    chk(c_rn == exp_n(20000, 0), "R5", "mono right N", c_rn, exp_n(20000, 0));
    mono = 0;

    // R6 right disabled, idle split
    ren = 0; idle = 2'd2;
    play(10000, 10000);
    chk(c_rp == FRAME && c_rn == 0, "R6", "disabled right P count", c_rp, FRAME);
    chk(oe == 4'b1111, "R6", "disabled right oe", int'(oe), 15);
    chk(c_lp == exp_p(10000, 0), "R6", "left unaffected", c_lp, exp_p(10000, 0));
    ren = 1; idle = 2'd0;

    // R8 false run: idle pads, samples still consumed
    frun = 1; valid = 1; sl = SW'(5000); sr = SW'(5000);
    begin
      int hs = 0; int hi = 0;
      for (int i = 0; i < 2 * FRAME; i++) begin
        @(negedge clk);
        if (ready && valid) hs++;
        if (i > 1) hi += int'(lp) + int'(ln) + int'(rp) + int'(rn);
      end
      chk(hs == 2, "R8", "handshakes in false run", hs, 2);
      chk(hi == 0, "R8", "pads active in false run", hi, 0);
    end
    idle = 2'd1;
    check_static("R8", 4'b1111, 4'b1111);
    frun = 0; valid = 0;

    // R7 idle codes while stopped
    run = 0;
    idle = 2'd0; check_static("R7", 4'b0000, 4'b1111);
    idle = 2'd1; check_static("R7", 4'b1111, 4'b1111);
    idle = 2'd2; check_static("R7", 4'b0101, 4'b1111);
    idle = 2'd3; check_static("R7", 4'b0000, 4'b0000);

    // R9 invert
    inv = 1;
    idle = 2'd0; check_static("R9", 4'b1111, 4'b1111);
    idle = 2'd3; check_static("R9", 4'b1111, 4'b0000);
    run = 1; idle = 2'd0;
    play(-7000, 7000);
    chk(c_lp == FRAME - exp_p(-7000, 0), "R9", "inverted left P", c_lp, FRAME - exp_p(-7000, 0));
    chk(c_rn == FRAME - exp_n(7000, 0), "R9", "inverted right N", c_rn, FRAME - exp_n(7000, 0));
    inv = 0;

    // R10 soft reset, held level acts once
    play(25000, -25000);
    valid = 0;
    srst = 1;
    repeat (5) @(negedge clk);
    srst = 0;
    repeat (2 * FRAME) @(negedge clk);
    measure();
    chk(c_lp == FRAME / 2, "R10", "left after soft reset", c_lp, FRAME / 2);
    chk(c_rp == FRAME / 2, "R10", "right after soft reset", c_rp, FRAME / 2);

    // R10 counter cleared: first ready comes FRAME cycles after clear
    begin
      int d = 0;
      srst = 1;
      @(negedge clk);
      srst = 0;
      @(negedge clk);
      while (!ready && d < 4 * FRAME) begin
        @(negedge clk);
        d++;
      end
      chk(d == FRAME - 1, "R10", "cycles to first ready", d, FRAME - 1);
    end

    // R11 registered pads: stop takes effect one edge later
    idle = 2'd1;
    @(negedge clk);
    run = 0;
    @(negedge clk);
    chk({rn, rp, ln, lp} == 4'b1111, "R11", "idle after one edge", int'({rn, rp, ln, lp}), 15);

    finish_run();
  end
endmodule